// File: doc/BRIEF.md
# Programmable Chip-Select Channel

One programmable chip-select channel for a 16-bit processor bus. At the first clock edge of every bus cycle, it decides whether the current access is for its device. It compares the access against two software-written registers. The comparison covers the access class derived from the function code, the upper address bits, the transfer direction, and the byte lanes the access touches. For interrupt-acknowledge cycles it also checks the priority level being acknowledged. When the access matches, the channel drives an active-low select. It then ends the cycle itself with an internal acknowledge after a programmed number of wait states. For an acknowledged interrupt it can request an autovector instead.

The channel is configured through a small write port with two registers. The base register holds the base address and a block-size code. The option register holds the mode, byte-lane, direction, strobe, acknowledge, space, priority and autovector fields. The decision is taken once per bus cycle. Each timing field is captured at that moment, so a register write takes effect from the next bus cycle. The select and the acknowledge drop as soon as the address strobe negates. External acknowledge pins stay outside this block and are always usable.

Top module: `csel_channel`

## Requirements
- R1: After reset both registers are zero. The byte-lane field is then 00, so no access asserts `cs_no`, `ack_o` or `avec_o`.
- R2: Outside CPU space, the access matches only if `addr_i[23:11]` equals base bits [15:3] on the compared bits. Base bits [2:0] give the block size: codes 0..7 mean 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes. The low address bits inside the block are not compared.
- R3: Space field (option [5:4]) 00 accepts only `fc_i`=7. Value 01 accepts `fc_i` 1 or 2, value 10 accepts 5 or 6, and value 11 accepts 1, 2, 5 or 6.
- R4: Direction field (option [12:11]) 00 never matches, 01 matches reads (`rw_i`=1), 10 matches writes, and 11 matches both.
- R5: An access touches the upper lane when `addr_i[0]`=0. It touches the lower lane when `addr_i[0]`=1 or `siz_i`≠01 (01 = byte). Byte field (option [14:13]) 00 never matches, 01 needs the lower lane, 10 needs the upper lane, and 11 accepts either.
- R6: In CPU space (space 00) the base is not compared. The access must have `addr_i[19:16]`=F. Its priority `addr_i[3:1]` must equal the priority field (option [3:1]), except that field value 000 accepts any priority.
- R7: Strobe bit (option [10]) =1 in asynchronous mode (option [15]=0) holds `cs_no` high until `ds_ni` is also low. In synchronous mode (option [15]=1) the select follows the address strobe alone. The select never asserts before the first rising edge of `clk_i` with `as_ni` low.
- R8: Let the capture edge be the first rising edge of `clk_i` with `as_ni` low. Acknowledge field (option [9:6]) value n in 0..13 raises `ack_o` n+1 clock edges after the capture edge. Value 14 raises it at the capture edge. `ack_o` is only high while the select is active.
- R9: Acknowledge field value 15 never raises `ack_o` while the select is still asserted.
- R10: On a CPU-space match with the autovector bit (option [0]) set, `avec_o` rises at the capture edge and `ack_o` stays low. With the bit clear, or outside CPU space, `avec_o` stays low.
- R11: `cs_no`, `ack_o` and `avec_o` return to inactive in the same instant `as_ni` goes high.
- R12: A register write made during a bus cycle changes neither that cycle's select nor its acknowledge timing. It applies from the next bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | 0 = base register, 1 = option register |
| reg_wdata_i | input | 16 | Register write data |
| addr_i | input | 24 | Bus address |
| fc_i | input | 3 | Function code |
| rw_i | input | 1 | 1 = read, 0 = write |
| siz_i | input | 2 | Transfer size (01 = byte, 10 = word) |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| cs_no | output | 1 | Chip select, active low |
| ack_o | output | 1 | Internal cycle acknowledge |
| avec_o | output | 1 | Autovector request |

## Verification
A wrong match result is captured at the capture edge. It shows half a clock later as a missing or unexpected select low, and it stays wrong for the whole cycle. A wrong wait count or a stale latched acknowledge field shows as `ack_o` rising at a different edge from n+1. A capture flag that is not cleared shows in the next bus cycle as a select that never drops or never asserts. A leak of the latched strobe or autovector choice shows when `ds_ni` is held back, or in the first interrupt-acknowledge cycle after a reprogram.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W   = 24;
  localparam int BASE_LSB = 11;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int BLK_W    = 3;
  localparam int ACK_W    = 4;
  localparam int PRIO_W   = 3;
  localparam int REG_W    = 16;

  localparam logic [ACK_W-1:0] ACK_FAST = ACK_W'(14);
  localparam logic [ACK_W-1:0] ACK_EXT  = ACK_W'(15);

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [BLK_W-1:0]  blksz;
  } base_reg_t;

  typedef struct packed {
    logic              sync_mode;
    logic [1:0]        lane;
    logic [1:0]        dir;
    logic              on_ds;
    logic [ACK_W-1:0]  ack_sel;
    logic [1:0]        space;
    logic [PRIO_W-1:0] prio;
    logic              avec;
  } opt_reg_t;

  // uncompared low bits of the base field per block-size code
  function automatic int unsigned blk_shift(input logic [BLK_W-1:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 7;
      3'd6: return 8;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output base_reg_t        base_o,
  output opt_reg_t         opt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      opt_o  <= '0;
    end else if (we_i) begin
      if (sel_i) opt_o  <= opt_reg_t'(wdata_i);
      else       base_o <= base_reg_t'(wdata_i);
    end
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic [1:0]        siz_i,
  input  base_reg_t         base_i,
  input  opt_reg_t          opt_i,
  output logic              hit_o,
  output logic              iack_o
);
  logic [BASE_W-1:0] mask;
  logic cpu_sp, user_sp, sup_sp;
  logic space_ok, addr_ok, dir_ok, lane_ok;
  logic lane_up, lane_lo;
  logic unused_addr;

  assign unused_addr = ^addr_i[BASE_LSB-1:4];

  always_comb begin
    for (int i = 0; i < BASE_W; i++)
      mask[i] = (i >= int'(blk_shift(base_i.blksz)));
  end

  assign cpu_sp  = (fc_i == 3'd7);
  assign user_sp = (fc_i == 3'd1) || (fc_i == 3'd2);
  assign sup_sp  = (fc_i == 3'd5) || (fc_i == 3'd6);

  always_comb begin
    case (opt_i.space)
      2'b00:   space_ok = cpu_sp;
      2'b01:   space_ok = user_sp;
      2'b10:   space_ok = sup_sp;
      default: space_ok = user_sp | sup_sp;
    endcase
  end

  assign iack_o = (opt_i.space == 2'b00);

  always_comb begin
    if (iack_o)
      addr_ok = (addr_i[19:16] == 4'hF) &&
                ((opt_i.prio == '0) || (addr_i[3:1] == opt_i.prio));
    else
      addr_ok = (((addr_i[ADDR_W-1:BASE_LSB] ^ base_i.base) & mask) == '0);
  end

  always_comb begin
    case (opt_i.dir)
      2'b01:   dir_ok = rw_i;
      2'b10:   dir_ok = !rw_i;
      2'b11:   dir_ok = 1'b1;
      default: dir_ok = 1'b0;
    endcase
  end

  assign lane_up = !addr_i[0];
  assign lane_lo = addr_i[0] || (siz_i != 2'b01);

  always_comb begin
    case (opt_i.lane)
      2'b01:   lane_ok = lane_lo;
      2'b10:   lane_ok = lane_up;
      2'b11:   lane_ok = 1'b1;
      default: lane_ok = 1'b0;
    endcase
  end

  assign hit_o = space_ok && addr_ok && dir_ok && lane_ok;
endmodule

// File: rtl/csel_timing.sv
module csel_timing
  import csel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_ni,
  input  logic             ds_ni,
  input  logic             hit_i,
  input  logic             wait_ds_i,
  input  logic             avec_i,
  input  logic [ACK_W-1:0] ack_sel_i,
  output logic             cs_no,
  output logic             ack_o,
  output logic             avec_o
);
  localparam int CNT_W = ACK_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             busy_q, hit_q, wait_ds_q, avec_q;
  logic [ACK_W-1:0] ack_sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start, cs_act, ready;

  assign start = !as_ni && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      hit_q     <= 1'b0;
      wait_ds_q <= 1'b0;
      avec_q    <= 1'b0;
      ack_sel_q <= '0;
      cnt_q     <= '0;
    end else if (as_ni) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (start) begin
      busy_q    <= 1'b1;
      hit_q     <= hit_i;
      wait_ds_q <= wait_ds_i;
      avec_q    <= avec_i;
      ack_sel_q <= ack_sel_i;
      cnt_q     <= '0;
    end else if (hit_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (ack_sel_q == ACK_FAST)     ready = 1'b1;
    else if (ack_sel_q == ACK_EXT) ready = 1'b0;
    else                           ready = (cnt_q > ack_sel_q);
  end

  assign cs_act = hit_q && !as_ni && (!wait_ds_q || !ds_ni);
  assign cs_no  = !cs_act;
  assign ack_o  = cs_act && ready && !avec_q;
  assign avec_o = cs_act && avec_q;
endmodule

// File: rtl/csel_channel.sv
module csel_channel
  import csel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic [1:0]        siz_i,
  input  logic              as_ni,
  input  logic              ds_ni,
  output logic              cs_no,
  output logic              ack_o,
  output logic              avec_o
);
  base_reg_t base_q;
  opt_reg_t  opt_q;
  logic      hit, iack;

  csel_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .base_o  (base_q),
    .opt_o   (opt_q)
  );

  csel_match u_match (
    .addr_i (addr_i),
    .fc_i   (fc_i),
    .rw_i   (rw_i),
    .siz_i  (siz_i),
    .base_i (base_q),
    .opt_i  (opt_q),
    .hit_o  (hit),
    .iack_o (iack)
  );

  csel_timing u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_ni     (as_ni),
    .ds_ni     (ds_ni),
    .hit_i     (hit),
    .wait_ds_i (opt_q.on_ds && !opt_q.sync_mode),
    .avec_i    (opt_q.avec && iack),
    .ack_sel_i (opt_q.ack_sel),
    .cs_no     (cs_no),
    .ack_o     (ack_o),
    .avec_o    (avec_o)
  );
endmodule

// File: rtl/csel_channel_chk.sv
module csel_channel_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic as_ni,
  input logic cs_no,
  input logic ack_o,
  input logic avec_o
);
  p_idle_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> (cs_no && !ack_o && !avec_o));

  p_cs_after_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !$past(as_ni));

  p_ack_inside_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !cs_no);

  p_ack_avec_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && avec_o));
endmodule

bind csel_channel csel_channel_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .as_ni  (as_ni),
  .cs_no  (cs_no),
  .ack_o  (ack_o),
  .avec_o (avec_o)
);

// File: tb/sim_csel_channel.sv
module sim_csel_channel;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [23:0] addr_i = '0;
  logic [2:0]  fc_i = '0;
  logic        rw_i = 1'b1;
  logic [1:0]  siz_i = 2'b01;
  logic        as_ni = 1'b1;
  logic        ds_ni = 1'b1;
  logic        cs_no, ack_o, avec_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  csel_channel u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_opt(input bit sync, input bit [1:0] lane,
      input bit [1:0] dir, input bit ds, input bit [3:0] ack, input bit [1:0] sp,
      input bit [2:0] prio, input bit av);
    return {sync, lane, dir, ds, ack, sp, prio, av};
  endfunction

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // runs one bus cycle, k=0 is the half cycle right after the capture edge
  task automatic bus(input logic [23:0] a, input logic [2:0] f, input bit rd,
                     input bit [1:0] sz, output bit cs_seen, output int ack_at,
                     output int av_at);
    @(negedge clk_i);
    addr_i = a; fc_i = f; rw_i = rd; siz_i = sz; as_ni = 1'b0; ds_ni = 1'b0;
    cs_seen = 0; ack_at = -1; av_at = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (!cs_no) cs_seen = 1;
      if (ack_o && ack_at < 0) ack_at = k;
      if (avec_o && av_at < 0) av_at = k;
    end
    as_ni = 1'b1; ds_ni = 1'b1;
    #1;
    chk("R11 release", {cs_no, ack_o, avec_o}, 3'b100);
  endtask

  task automatic expect_bus(input string tag, input logic [23:0] a, input logic [2:0] f,
                            input bit rd, input bit [1:0] sz, input bit e_cs,
                            input int e_ack, input int e_av);
    bit c; int ak; int av;
    bus(a, f, rd, sz, c, ak, av);
    chk({tag, " cs"}, c, e_cs);
    chk({tag, " ack"}, ak, e_ack);
    chk({tag, " avec"}, av, e_av);
  endtask

  task automatic t_reset;
    chk("R1 idle outputs", {cs_no, ack_o, avec_o}, 3'b100);
    expect_bus("R1 after reset", 24'h000000, 3'd5, 1, 2'b01, 0, -1, -1);
  endtask

  task automatic t_base;
    wr(0, {13'h0080, 3'd3});  // 0x040000, 64K
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd2, 2'b10, 3'd0, 0));
    expect_bus("R2 64K top", 24'h04FFFE, 3'd5, 1, 2'b10, 1, 3, -1);
    expect_bus("R2 64K above", 24'h050000, 3'd5, 1, 2'b10, 0, -1, -1);
    wr(0, {13'h0080, 3'd0});  // 2K
    expect_bus("R2 2K in", 24'h0407FE, 3'd5, 1, 2'b10, 1, 3, -1);
    expect_bus("R2 2K out", 24'h040800, 3'd5, 1, 2'b10, 0, -1, -1);
  endtask

  task automatic t_space;
    wr(0, {13'h0080, 3'd7});
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b01, 3'd0, 0));
    expect_bus("R3 user rejects sup", 24'h040000, 3'd5, 1, 2'b10, 0, -1, -1);
    expect_bus("R3 user data", 24'h040000, 3'd1, 1, 2'b10, 1, 1, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b11, 3'd0, 0));
    expect_bus("R3 both sup prog", 24'h040000, 3'd6, 1, 2'b10, 1, 1, -1);
    expect_bus("R3 both user prog", 24'h040000, 3'd2, 1, 2'b10, 1, 1, -1);
    expect_bus("R3 both rejects cpu", 24'h040000, 3'd7, 1, 2'b10, 0, -1, -1);
  endtask

  task automatic t_dir;
    wr(1, mk_opt(0, 2'b11, 2'b01, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R4 rd-only write", 24'h040000, 3'd5, 0, 2'b10, 0, -1, -1);
    expect_bus("R4 rd-only read", 24'h040000, 3'd5, 1, 2'b10, 1, 1, -1);
    wr(1, mk_opt(0, 2'b11, 2'b10, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R4 wr-only read", 24'h040000, 3'd5, 1, 2'b10, 0, -1, -1);
    expect_bus("R4 wr-only write", 24'h040000, 3'd5, 0, 2'b10, 1, 1, -1);
    wr(1, mk_opt(0, 2'b11, 2'b00, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R4 none", 24'h040000, 3'd5, 1, 2'b10, 0, -1, -1);
  endtask

  task automatic t_lane;
    wr(1, mk_opt(0, 2'b10, 2'b11, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R5 upper even byte", 24'h040010, 3'd5, 1, 2'b01, 1, 1, -1);
    expect_bus("R5 upper odd byte", 24'h040011, 3'd5, 1, 2'b01, 0, -1, -1);
    wr(1, mk_opt(0, 2'b01, 2'b11, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R5 lower odd byte", 24'h040011, 3'd5, 1, 2'b01, 1, 1, -1);
    expect_bus("R5 lower even byte", 24'h040010, 3'd5, 1, 2'b01, 0, -1, -1);
    expect_bus("R5 lower even word", 24'h040010, 3'd5, 1, 2'b10, 1, 1, -1);
  endtask

  task automatic t_iack;
    wr(0, {13'h1FFF, 3'd0});  // base far from the iack addresses
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b00, 3'd3, 0));
    expect_bus("R6 prio 3 match", 24'h0F0007, 3'd7, 1, 2'b01, 1, 1, -1);
    expect_bus("R6 prio 5 miss", 24'h0F000B, 3'd7, 1, 2'b01, 0, -1, -1);
    expect_bus("R6 not iack type", 24'h0E0007, 3'd7, 1, 2'b01, 0, -1, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b00, 3'd0, 0));
    expect_bus("R6 wildcard prio 5", 24'h0F000B, 3'd7, 1, 2'b01, 1, 1, -1);
    expect_bus("R6 wrong fc", 24'h0F000B, 3'd5, 1, 2'b01, 0, -1, -1);
  endtask

  task automatic t_strobe;
    wr(0, {13'h0080, 3'd7});
    wr(1, mk_opt(0, 2'b11, 2'b11, 1, 4'd14, 2'b10, 3'd0, 0));
    @(negedge clk_i);
    addr_i = 24'h040000; fc_i = 3'd5; rw_i = 1; siz_i = 2'b10; as_ni = 0; ds_ni = 1;
    @(negedge clk_i);
    chk("R7 ds wait: cs held", cs_no, 1);
    chk("R7 ds wait: no ack", ack_o, 0);
    ds_ni = 0;
    #1;
    chk("R7 ds low: cs", cs_no, 0);
    chk("R7 ds low: ack", ack_o, 1);
    @(negedge clk_i);
    as_ni = 1; ds_ni = 1;
    #1;
    chk("R11 ds cycle release", cs_no, 1);
    wr(1, mk_opt(1, 2'b11, 2'b11, 1, 4'd14, 2'b10, 3'd0, 0));
    @(negedge clk_i);
    as_ni = 0; ds_ni = 1;
    #1;
    chk("R7 no select before capture", cs_no, 1);
    @(negedge clk_i);
    chk("R7 sync ignores ds", cs_no, 0);
    as_ni = 1;
    #1;
    chk("R11 sync release", cs_no, 1);
  endtask

  task automatic t_ack;
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b10, 3'd0, 0));
    expect_bus("R8 zero waits", 24'h040000, 3'd5, 1, 2'b10, 1, 1, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd5, 2'b10, 3'd0, 0));
    expect_bus("R8 five waits", 24'h040000, 3'd5, 1, 2'b10, 1, 6, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd13, 2'b10, 3'd0, 0));
    expect_bus("R8 thirteen waits", 24'h040000, 3'd5, 1, 2'b10, 1, 14, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd14, 2'b10, 3'd0, 0));
    expect_bus("R8 fast", 24'h040000, 3'd5, 1, 2'b10, 1, 0, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd15, 2'b10, 3'd0, 0));
    expect_bus("R9 external only", 24'h040000, 3'd5, 1, 2'b10, 1, -1, -1);
  endtask

  task automatic t_avec;
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd3, 2'b00, 3'd2, 1));
    expect_bus("R10 iack autovector", 24'h0F0005, 3'd7, 1, 2'b01, 1, -1, 0);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd3, 2'b00, 3'd2, 0));
    expect_bus("R10 iack vector by ack", 24'h0F0005, 3'd7, 1, 2'b01, 1, 4, -1);
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd3, 2'b10, 3'd0, 1));
    expect_bus("R10 avec bit outside cpu", 24'h040000, 3'd5, 1, 2'b10, 1, 4, -1);
  endtask

  task automatic t_midwrite;
    int ak;
    bit cs_lost;
    wr(1, mk_opt(0, 2'b11, 2'b11, 0, 4'd5, 2'b10, 3'd0, 0));
    @(negedge clk_i);
    addr_i = 24'h040000; fc_i = 3'd5; rw_i = 1; siz_i = 2'b10; as_ni = 0; ds_ni = 0;
    ak = -1; cs_lost = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      if (cs_no) cs_lost = 1;
      if (ack_o && ak < 0) ak = k;
      if (k == 0) begin
        reg_we_i = 1; reg_sel_i = 1;
        reg_wdata_i = mk_opt(0, 2'b11, 2'b00, 0, 4'd0, 2'b10, 3'd0, 0);
      end else begin
        reg_we_i = 0;
      end
    end
    chk("R12 select kept", cs_lost, 0);
    chk("R12 old ack timing", ak, 6);
    as_ni = 1; ds_ni = 1;
    expect_bus("R12 new options next cycle", 24'h040000, 3'd5, 1, 2'b10, 0, -1, -1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_base();
    t_space();
    t_dir();
    t_lane();
    t_iack();
    t_strobe();
    t_ack();
    t_avec();
    t_midwrite();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule